// File: doc/BRIEF.md
# Inbound Cache Snoop Controller

This block sits on the inbound path of a PCI target, between the request that the PCI side presents and the internal system bus. It handles one access at a time. It captures the access address and checks it against two programmable snoop windows. Each window is a base address plus a mask. The results of the two windows are ORed into a single hit.

On a hit, the block asks the CPU to flush or purge the cache line that holds the address. It waits for the CPU to acknowledge, then issues the memory read or write. On a miss, the memory access is issued at once. If a hit arrives while the CPU reports that it is asleep, the access is dropped and a bus error is returned.

A two-bit mode field chooses flush, purge or off. A configuration error flag warns when snooping and inbound prefetch are both enabled.

Top module: `pci_snoop_ctrl`

## Requirements
- R1: Window n matches when (addr & mask_n) == (base_n & mask_n). A hit is the OR of all window matches, gated by the snoop mode.
- R2: On a hit with the CPU awake, `cache_req_o` asserts with `cache_addr_o` equal to the access address with its low 5 bits cleared (32-byte lines). It stays asserted until the cycle in which `cache_ack_i` is sampled high. `mem_req_o` stays low while `cache_req_o` is high.
- R3: Mode 2'b01 requests a flush (`cache_purge_o` = 0). Mode 2'b10 requests a purge (`cache_purge_o` = 1).
- R4: Mode 2'b00 (off) and mode 2'b11 (reserved) treat every access as a miss.
- R5: On a miss, `mem_req_o` asserts with no cache request. It carries the captured address and write flag, and it holds with a stable address until `mem_done_i` is sampled high.
- R6: A hit while `cpu_sleep_i` is high issues neither a cache request nor a memory request. Instead, `bus_err_o` pulses for exactly one cycle.
- R7: `cfg_err_o` is high exactly when `prefetch_en_i` is high and the mode is 2'b01 or 2'b10.
- R8: `req_ready_o` is high only when the block is idle. It drops in the cycle after acceptance and returns in the cycle after `mem_done_i` or the error pulse, so only one access is in flight.
- R9: During reset, `req_ready_o` is high and `cache_req_o`, `mem_req_o` and `bus_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Inbound access valid |
| req_ready_o | output | 1 | Block can accept an access |
| req_addr_i | input | 32 | Inbound access address |
| req_write_i | input | 1 | Inbound access is a write |
| win_base_i | input | 2x32 | Snoop window base addresses |
| win_mask_i | input | 2x32 | Snoop window compare masks |
| snoop_mode_i | input | 2 | 00 off, 01 flush, 10 purge, 11 off |
| prefetch_en_i | input | 1 | Inbound prefetch enabled |
| cpu_sleep_i | input | 1 | CPU is in sleep state |
| cache_req_o | output | 1 | Cache flush/purge request to the CPU |
| cache_purge_o | output | 1 | 1 selects purge, 0 selects flush |
| cache_addr_o | output | 32 | Line-aligned address of the request |
| cache_ack_i | input | 1 | CPU finished the cache operation |
| mem_req_o | output | 1 | Memory access request |
| mem_addr_o | output | 32 | Memory access address |
| mem_write_o | output | 1 | Memory access is a write |
| mem_done_i | input | 1 | Memory access complete |
| bus_err_o | output | 1 | Error response pulse |
| cfg_err_o | output | 1 | Snoop and prefetch both enabled |

## Verification
The assertions assume that `cache_ack_i` arrives only while a cache request is pending and `mem_done_i` only while a memory request is pending. They also assume that the window registers, the mode and `cpu_sleep_i` stay stable during an access. The stimulus keeps to these rules. It changes the configuration only between transactions, while the block is idle. It returns each acknowledge as a one-cycle pulse in reply to an observed request.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  typedef enum logic [1:0] {
    SNP_OFF   = 2'b00,
    SNP_FLUSH = 2'b01,
    SNP_PURGE = 2'b10,
    SNP_RSVD  = 2'b11
  } snoop_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COMPARE,
    ST_CACHE_REQ,
    ST_ACCESS,
    ST_ERROR
  } snoop_state_e;
endpackage

// File: rtl/snoop_window.sv
module snoop_window #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] mask_i,
  output logic              match_o
);
  always_comb match_o = ((addr_i & mask_i) == (base_i & mask_i));
endmodule

// File: rtl/snoop_mode_dec.sv
module snoop_mode_dec
  import snoop_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       prefetch_en_i,
  output logic       snoop_on_o,
  output logic       purge_o,
  output logic       cfg_err_o
);
  snoop_mode_e mode;
  always_comb begin
    mode       = snoop_mode_e'(mode_i);
    snoop_on_o = 1'b0;
    purge_o    = 1'b0;
    unique case (mode)
      SNP_FLUSH: snoop_on_o = 1'b1;
      SNP_PURGE: begin snoop_on_o = 1'b1; purge_o = 1'b1; end
      default:   snoop_on_o = 1'b0;  // off and reserved
    endcase
    cfg_err_o = snoop_on_o & prefetch_en_i;
  end
endmodule

// File: rtl/snoop_fsm.sv
module snoop_fsm
  import snoop_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LINE_LSB = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  output logic              req_ready_o,
  output logic [ADDR_W-1:0] cap_addr_o,
  input  logic              hit_i,
  input  logic              purge_i,
  input  logic              cpu_sleep_i,
  output logic              cache_req_o,
  output logic              cache_purge_o,
  output logic [ADDR_W-1:0] cache_addr_o,
  input  logic              cache_ack_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_write_o,
  input  logic              mem_done_i,
  output logic              bus_err_o
);
  localparam logic [ADDR_W-1:0] LINE_MASK = ~((ADDR_W'(1) << LINE_LSB) - ADDR_W'(1));

  snoop_state_e state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              write_q, purge_q;
  logic              accept;

  assign accept = req_valid_i && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (req_valid_i) state_d = ST_COMPARE;
      ST_COMPARE: begin
        if (!hit_i)           state_d = ST_ACCESS;
        else if (cpu_sleep_i) state_d = ST_ERROR;
        else                  state_d = ST_CACHE_REQ;
      end
      ST_CACHE_REQ: if (cache_ack_i) state_d = ST_ACCESS;
      ST_ACCESS:    if (mem_done_i)  state_d = ST_IDLE;
      ST_ERROR:     state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      write_q <= 1'b0;
      purge_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q  <= req_addr_i;
        write_q <= req_write_i;
      end
      if (state_q == ST_COMPARE) purge_q <= purge_i;
    end
  end

  assign req_ready_o   = (state_q == ST_IDLE);
  assign cap_addr_o    = addr_q;
  assign cache_req_o   = (state_q == ST_CACHE_REQ);
  assign cache_purge_o = purge_q;
  assign cache_addr_o  = addr_q & LINE_MASK;
  assign mem_req_o     = (state_q == ST_ACCESS);
  assign mem_addr_o    = addr_q;
  assign mem_write_o   = write_q;
  assign bus_err_o     = (state_q == ST_ERROR);
endmodule

// File: rtl/pci_snoop_ctrl.sv
module pci_snoop_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int NUM_WIN    = 2,
  parameter int LINE_BYTES = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_valid_i,
  output logic                           req_ready_o,
  input  logic [ADDR_W-1:0]              req_addr_i,
  input  logic                           req_write_i,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] win_base_i,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] win_mask_i,
  input  logic [1:0]                     snoop_mode_i,
  input  logic                           prefetch_en_i,
  input  logic                           cpu_sleep_i,
  output logic                           cache_req_o,
  output logic                           cache_purge_o,
  output logic [ADDR_W-1:0]              cache_addr_o,
  input  logic                           cache_ack_i,
  output logic                           mem_req_o,
  output logic [ADDR_W-1:0]              mem_addr_o,
  output logic                           mem_write_o,
  input  logic                           mem_done_i,
  output logic                           bus_err_o,
  output logic                           cfg_err_o
);
  localparam int LINE_LSB = $clog2(LINE_BYTES);

  logic [ADDR_W-1:0]  cap_addr;
  logic [NUM_WIN-1:0] win_match;
  logic               snoop_on, purge, hit;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    snoop_window #(.ADDR_W(ADDR_W)) u_win (
      .addr_i (cap_addr),
      .base_i (win_base_i[w]),
      .mask_i (win_mask_i[w]),
      .match_o(win_match[w])
    );
  end

  snoop_mode_dec u_mode (
    .mode_i       (snoop_mode_i),
    .prefetch_en_i(prefetch_en_i),
    .snoop_on_o   (snoop_on),
    .purge_o      (purge),
    .cfg_err_o    (cfg_err_o)
  );

  assign hit = snoop_on && (|win_match);

  snoop_fsm #(.ADDR_W(ADDR_W), .LINE_LSB(LINE_LSB)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_addr_i   (req_addr_i),
    .req_write_i  (req_write_i),
    .req_ready_o  (req_ready_o),
    .cap_addr_o   (cap_addr),
    .hit_i        (hit),
    .purge_i      (purge),
    .cpu_sleep_i  (cpu_sleep_i),
    .cache_req_o  (cache_req_o),
    .cache_purge_o(cache_purge_o),
    .cache_addr_o (cache_addr_o),
    .cache_ack_i  (cache_ack_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_write_o  (mem_write_o),
    .mem_done_i   (mem_done_i),
    .bus_err_o    (bus_err_o)
  );
endmodule

// File: rtl/pci_snoop_ctrl_chk.sv
module pci_snoop_ctrl_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              cache_req_o,
  input logic [ADDR_W-1:0] cache_addr_o,
  input logic              cache_ack_i,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_done_i,
  input logic              bus_err_o
);
  localparam int LSB = $clog2(LINE_BYTES);

  p_no_mem_during_cache_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_req_o |-> !mem_req_o);
  p_cache_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_req_o && !cache_ack_i |=> cache_req_o && $stable(cache_addr_o));
  p_line_align_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_req_o |-> (cache_addr_o[LSB-1:0] == '0));
  p_mem_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_done_i |=> mem_req_o && $stable(mem_addr_o));
  p_err_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |=> !bus_err_o);
  p_err_no_mem_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |-> !mem_req_o && !cache_req_o);
  p_busy_not_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o || cache_req_o || bus_err_o) |-> !req_ready_o);
  p_accept_drops_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);
endmodule

bind pci_snoop_ctrl pci_snoop_ctrl_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .cache_req_o (cache_req_o),
  .cache_addr_o(cache_addr_o),
  .cache_ack_i (cache_ack_i),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_done_i  (mem_done_i),
  .bus_err_o   (bus_err_o)
);

// File: tb/pci_snoop_ctrl_tb.sv
module pci_snoop_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0][31:0] win_base, win_mask;
  logic [1:0] mode = 2'b00;
  logic prefetch = 1'b0, sleep = 1'b0, cache_ack = 1'b0, mem_done = 1'b0;
  logic req_ready, cache_req, cache_purge, mem_req, mem_write, bus_err, cfg_err;
  logic [31:0] cache_addr, mem_addr;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign win_base = {32'h8000_4000, 32'h1000_0000};
  assign win_mask = {32'hFFFF_C000, 32'hFFF0_0000};

  pci_snoop_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_write_i(req_write), .win_base_i(win_base),
    .win_mask_i(win_mask), .snoop_mode_i(mode), .prefetch_en_i(prefetch),
    .cpu_sleep_i(sleep), .cache_req_o(cache_req), .cache_purge_o(cache_purge),
    .cache_addr_o(cache_addr), .cache_ack_i(cache_ack), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_write_o(mem_write), .mem_done_i(mem_done),
    .bus_err_o(bus_err), .cfg_err_o(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // exp: 0 miss, 1 hit, 2 error
  typedef struct packed {
    logic [31:0] addr;
    logic        wr;
    logic [1:0]  md;
    logic        slp;
    logic [1:0]  exp;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{32'h1000_0044, 1'b0, 2'b01, 1'b0, 2'd1},  // R1 win0, R3 flush
    '{32'h100F_FFFF, 1'b1, 2'b10, 1'b0, 2'd1},  // R1 win0 edge, R3 purge
    '{32'h1010_0000, 1'b0, 2'b01, 1'b0, 2'd0},  // R5 just past win0
    '{32'h8000_7ABC, 1'b1, 2'b01, 1'b0, 2'd1},  // R1 win1
    '{32'h8000_8000, 1'b0, 2'b10, 1'b0, 2'd0},  // R5 past win1
    '{32'h1000_0044, 1'b1, 2'b00, 1'b0, 2'd0},  // R4 off
    '{32'h1000_0044, 1'b0, 2'b11, 1'b0, 2'd0},  // R4 reserved
    '{32'h8000_4000, 1'b1, 2'b10, 1'b1, 2'd2},  // R6 hit asleep
    '{32'h2000_0000, 1'b0, 2'b01, 1'b1, 2'd0},  // R5 miss asleep
    '{32'h1000_0000, 1'b1, 2'b00, 1'b1, 2'd0}   // R4 off asleep
  };

  task automatic run(input logic [31:0] a, input logic w,
                     output bit c_seen, output int c_cnt, output logic [31:0] c_addr,
                     output logic c_purge, output bit m_seen, output logic [31:0] m_addr,
                     output logic m_wr, output bit err, output bit rdy_low, output bit rdy_back,
                     output bit err_pulse);
    bit done = 0;
    c_seen = 0; c_cnt = 0; c_addr = '0; c_purge = 0; m_seen = 0; m_addr = '0;
    m_wr = 0; err = 0; rdy_back = 0; err_pulse = 1;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    rdy_low = !req_ready;
    for (int i = 0; i < 30 && !done; i++) begin
      if (cache_req) begin
        c_seen = 1; c_cnt++; c_addr = cache_addr; c_purge = cache_purge;
        if (mem_req) m_seen = 1;
        if (c_cnt == 2) cache_ack = 1'b1;
        @(posedge clk); @(negedge clk);
        cache_ack = 1'b0;
      end else if (mem_req) begin
        m_seen = 1; m_addr = mem_addr; m_wr = mem_write;
        mem_done = 1'b1;
        @(posedge clk); @(negedge clk);
        mem_done = 1'b0;
        rdy_back = req_ready; done = 1;
      end else if (bus_err) begin
        err = 1;
        @(posedge clk); @(negedge clk);
        err_pulse = !bus_err;
        rdy_back = req_ready; done = 1;
      end else begin
        @(posedge clk); @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=<%0d", WATCHDOG, WATCHDOG);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit cs, ms, er, rl, rb, ep;
    int cc;
    logic [31:0] ca, ma;
    logic cp, mw;

    repeat (3) @(negedge clk);
    chk(req_ready && !cache_req && !mem_req && !bus_err, "R9 reset outputs",
        {28'd0, req_ready, cache_req, mem_req, bus_err}, 32'h8);
    rst_n = 1'b1;

    for (int v = 0; v < 10; v++) begin
      @(negedge clk);
      mode = VEC[v].md; sleep = VEC[v].slp;
      run(VEC[v].addr, VEC[v].wr, cs, cc, ca, cp, ms, ma, mw, er, rl, rb, ep);
      chk(rl, "R8 ready low after accept", 32'(rl), 32'd1);
      if (VEC[v].exp == 2'd1) begin
        chk(cs, "R1 hit gives cache request", 32'(cs), 32'd1);
        chk(ca == (VEC[v].addr & 32'hFFFF_FFE0), "R2 line address", ca, VEC[v].addr & 32'hFFFF_FFE0);
        chk(cc == 2, "R2 request held until ack", 32'(cc), 32'd2);
        chk(cp == (VEC[v].md == 2'b10), "R3 flush/purge select", 32'(cp), 32'(VEC[v].md == 2'b10));
      end else if (VEC[v].exp == 2'd0) begin
        chk(!cs, "R4/R5 miss has no cache request", 32'(cs), 32'd0);
      end
      if (VEC[v].exp == 2'd2) begin
        chk(er && !ms && !cs, "R6 sleep hit gives error only",
            {29'd0, er, ms, cs}, 32'h4);
        chk(ep, "R6 error is one cycle", 32'(ep), 32'd1);
      end else begin
        chk(ms && ma == VEC[v].addr, "R5 memory address", ma, VEC[v].addr);
        chk(mw == VEC[v].wr, "R5 memory write flag", 32'(mw), 32'(VEC[v].wr));
        chk(!er, "R6 no error when awake or miss", 32'(er), 32'd0);
      end
      chk(rb, "R8 ready returns after completion", 32'(rb), 32'd1);
    end

    // R7 configuration error decode
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 2; p++) begin
        @(negedge clk);
        mode = 2'(m); prefetch = p[0];
        #1;
        chk(cfg_err == (p == 1 && (m == 1 || m == 2)), "R7 cfg error",
            32'(cfg_err), 32'(p == 1 && (m == 1 || m == 2)));
      end
    end
    prefetch = 1'b0;

    // R8: valid held high is accepted only once per completion
    @(negedge clk);
    mode = 2'b01; sleep = 1'b0;
    req_valid = 1'b1; req_addr = 32'h3000_0000; req_write = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(!req_ready, "R8 busy while valid held", 32'(req_ready), 32'd0);
    @(posedge clk); @(negedge clk);
    chk(mem_req && !req_ready, "R8 one access in flight", {30'd0, mem_req, req_ready}, 32'h2);
    req_valid = 1'b0; mem_done = 1'b1;
    @(posedge clk); @(negedge clk);
    mem_done = 1'b0;
    chk(req_ready && !mem_req, "R8 idle after done", {30'd0, req_ready, mem_req}, 32'h2);

    // R9 asynchronous reset mid-transaction
    req_valid = 1'b1; req_addr = 32'h1000_0100;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    rst_n = 1'b0; #1;
    chk(req_ready && !cache_req && !mem_req, "R9 reset aborts access",
        {29'd0, req_ready, cache_req, mem_req}, 32'h4);
    @(negedge clk);
    rst_n = 1'b1;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule